// File: doc/BRIEF.md
# 16-bit Timer with Event Capture

This block is a 16-bit up-counter reached by a processor through an 8-bit register bus. The counter advances on a timer tick. The tick comes from one of seven prescaled enable inputs, chosen by a 3-bit clock-select field. A select value of zero freezes the counter. An optional clear-on-compare mode makes the compare value the top of the count. Otherwise the count runs up to 0xFFFF and wraps. Overflow, compare match and capture each raise a sticky flag. Each flag, gated by its enable bit, drives an interrupt line.

The capture path timestamps external events. The trigger comes from either a capture pin or a comparator output. It is synchronised and can be filtered by a noise canceler. An edge detector of selectable polarity then turns it into an event. In capture mode the compare register is taken over as the capture register, so an event copies the live count into it.

The 16-bit count and the compare/capture register are accessed through one shared 8-bit temporary byte. This makes both reads and writes of a 16-bit value atomic.

Register map (3-bit address, bit 0 selects low/high byte):
- 0 control: [2:0] clock select, [3] clear-on-compare, [4] capture mode, [5] noise canceler enable, [6] edge select (1 rising, 0 falling), [7] trigger source (0 pin, 1 comparator).
- 1 interrupt enables, 2 flags: bit 0 overflow, bit 1 compare match, bit 2 capture. Address 3 reads as zero.
- 4/5 count low/high, 6/7 compare-capture low/high.

Top module: `tcap_timer16`

## Requirements
- R1: After reset the count, control, enables, flags, compare register and read data are all zero, and all interrupt lines are low.
- R2: With clock select 0 the count never changes. With select n (1..7) the count advances only on cycles where tick_src[n-1] is high.
- R3: Outside clear-on-compare, each tick adds one to the count, and 0xFFFF wraps to 0x0000.
- R4: With control bit 3 set and capture mode off, a tick while the count equals the compare register loads 0. A count above the compare value keeps counting up.
- R5: A count low-byte write commits {temp, data}, and it overrides an increment or clear in the same cycle.
- R6: Flag bit 0 is set by a tick while the count is 0xFFFF. Flag bit 1 is set by a tick while the count equals the compare register and capture mode is off.
- R7: Writing 1 to a flag bit clears it and writing 0 leaves it. A set event in the same cycle as a clear wins.
- R8: Control bit 7 picks the trigger. Activity on the unselected input produces no capture.
- R9: Control bit 6 selects the rising (1) or falling (0) edge. Edges of the other polarity produce no capture.
- R10: With capture mode on, a detected edge copies the count into the compare-capture register and sets flag bit 2. With capture mode off, edges leave that register and flag bit 2 untouched.
- R11: With control bit 5 set, a level lasting fewer than 5 clocks is rejected, and an accepted edge arrives exactly 4 clocks later than with the canceler off. With bit 5 clear, a 2-clock pulse is captured.
- R12: A low-byte read latches the high byte into the temporary byte, and the next high-byte read returns it. A high-byte write only loads the temporary byte. Read data appears the cycle after the read strobe.
- R13: Each interrupt line is high exactly when its flag bit and the enable bit at the same position are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_src | input | 7 | Prescaled tick enables, selected by clock select |
| cap_pin | input | 1 | External capture input |
| acmp_out | input | 1 | Comparator output, alternative capture input |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare match interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
Some properties are checked on every cycle: the counter's hold, increment and clear-on-compare rules, the priority of a processor count write, and flag setting on overflow. The capture copy, and the frozen compare register outside capture mode, are also watched continuously. Other behaviour only the bench's scenarios can show, because it spans several bus transactions or timed input waveforms. This covers the shared temporary byte ordering, glitch rejection, the exact four-clock latency of the noise canceler, trigger source and polarity selection, and interrupt gating.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  localparam int CS_W   = 3;
  localparam int ADDR_W = 3;
  localparam int FLG_W  = 3;

  localparam int FLG_OVF = 0;
  localparam int FLG_CMP = 1;
  localparam int FLG_CAP = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_IEN    = 3'd1,
    A_FLAG   = 3'd2,
    A_RSVD   = 3'd3,
    A_CNT_LO = 3'd4,
    A_CNT_HI = 3'd5,
    A_CMP_LO = 3'd6,
    A_CMP_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic            src_cmp;
    logic            rise;
    logic            nc_en;
    logic            cap_mode;
    logic            coc;
    logic [CS_W-1:0] cs;
  } ctrl_t;

endpackage

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int CNT_W = 16,
  parameter int CS_W  = 3,
  localparam int NSRC = (1 << CS_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CS_W-1:0]  cs,
  input  logic             coc_en,
  input  logic [NSRC-1:0]  tick_src,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick_o,
  output logic             ovf_evt,
  output logic             cmp_evt
);

  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic tick;
  logic at_cmp;
  logic at_max;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (cs == CS_W'(i + 1)) tick = tick_src[i];
    end
  end

  assign at_cmp  = (cnt_q == top_val);
  assign at_max  = (cnt_q == MAX_VAL);
  assign tick_o  = tick;
  assign ovf_evt = tick & at_max;
  assign cmp_evt = tick & at_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_en) begin
      cnt_q <= wr_val;
    end else if (tick) begin
      if (coc_en && at_cmp) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tcap_capture_front.sv
module tcap_capture_front #(
  parameter int SYNC_W   = 2,
  parameter int NC_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_pin,
  input  logic acmp_out,
  input  logic src_cmp,
  input  logic nc_en,
  input  logic rise,
  output logic cap_evt
);

  logic                raw;
  logic [SYNC_W-1:0]   sync_q;
  logic                synced;
  logic [NC_DEPTH-1:0] hist_q;
  logic                all_eq;
  logic                lvl_q;
  logic                prev_q;

  assign raw    = src_cmp ? acmp_out : cap_pin;
  assign synced = sync_q[SYNC_W-1];
  assign all_eq = (hist_q == {NC_DEPTH{synced}});

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], raw};
      hist_q <= {hist_q[NC_DEPTH-2:0], synced};
      if (!nc_en || all_eq) lvl_q <= synced;
      prev_q <= lvl_q;
    end
  end

  assign cap_evt = rise ? (lvl_q & ~prev_q) : (~lvl_q & prev_q);

endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              ovf_evt,
  input  logic              cmp_evt,
  input  logic              cap_evt,
  output ctrl_t             ctrl_q,
  output logic [FLG_W-1:0]  flags_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              cnt_wr,
  output logic              cmp_wr,
  output logic [CNT_W-1:0]  wr_val,
  output logic [FLG_W-1:0]  irq
);

  logic [DATA_W-1:0] temp_q;
  logic [FLG_W-1:0]  ien_q;
  logic [FLG_W-1:0]  set_v;
  logic [FLG_W-1:0]  clr_v;
  logic              cap_take;

  assign cnt_wr   = bus_wr && (bus_addr == A_CNT_LO);
  assign cmp_wr   = bus_wr && (bus_addr == A_CMP_LO);
  assign wr_val   = {temp_q, bus_wdata};
  assign cap_take = cap_evt && ctrl_q.cap_mode;

  always_comb begin
    set_v          = '0;
    set_v[FLG_OVF] = ovf_evt;
    set_v[FLG_CMP] = cmp_evt && !ctrl_q.cap_mode;
    set_v[FLG_CAP] = cap_take;
    clr_v = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[FLG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      temp_q  <= '0;
      cmp_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_v) | set_v;
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (bus_wr && bus_addr == A_IEN)  ien_q  <= bus_wdata[FLG_W-1:0];
      if (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CMP_HI)) begin
        temp_q <= bus_wdata;
      end else if (bus_rd && bus_addr == A_CNT_LO) begin
        temp_q <= cnt_q[CNT_W-1:DATA_W];
      end else if (bus_rd && bus_addr == A_CMP_LO) begin
        temp_q <= cmp_q[CNT_W-1:DATA_W];
      end
      if (cmp_wr)        cmp_q <= wr_val;
      else if (cap_take) cmp_q <= cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
        A_IEN:    bus_rdata <= DATA_W'(ien_q);
        A_FLAG:   bus_rdata <= DATA_W'(flags_q);
        A_CNT_LO: bus_rdata <= cnt_q[DATA_W-1:0];
        A_CMP_LO: bus_rdata <= cmp_q[DATA_W-1:0];
        A_CNT_HI,
        A_CMP_HI: bus_rdata <= temp_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq = flags_q & ien_q;

endmodule

// File: rtl/tcap_timer16.sv
module tcap_timer16
  import tcap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_W   = 2,
  parameter int NC_DEPTH = 4,
  localparam int CNT_W   = 2 * DATA_W,
  localparam int NSRC    = (1 << CS_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   tick_src,
  input  logic              cap_pin,
  input  logic              acmp_out,
  output logic              irq_ovf,
  output logic              irq_cmp,
  output logic              irq_cap
);

  ctrl_t             ctrl_q;
  logic [FLG_W-1:0]  flags_q;
  logic [FLG_W-1:0]  irq;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  wr_val;
  logic              cnt_wr;
  logic              cmp_wr;
  logic              cnt_tick;
  logic              ovf_evt;
  logic              cmp_evt;
  logic              cap_evt;
  logic              coc_eff;

  assign coc_eff = ctrl_q.coc & ~ctrl_q.cap_mode;

  tcap_counter #(
    .CNT_W (CNT_W),
    .CS_W  (CS_W)
  ) counter_i (
    .clk      (clk),
    .rst      (rst),
    .cs       (ctrl_q.cs),
    .coc_en   (coc_eff),
    .tick_src (tick_src),
    .wr_en    (cnt_wr),
    .wr_val   (wr_val),
    .top_val  (cmp_q),
    .cnt_q    (cnt_q),
    .tick_o   (cnt_tick),
    .ovf_evt  (ovf_evt),
    .cmp_evt  (cmp_evt)
  );

  tcap_capture_front #(
    .SYNC_W   (SYNC_W),
    .NC_DEPTH (NC_DEPTH)
  ) front_i (
    .clk      (clk),
    .rst      (rst),
    .cap_pin  (cap_pin),
    .acmp_out (acmp_out),
    .src_cmp  (ctrl_q.src_cmp),
    .nc_en    (ctrl_q.nc_en),
    .rise     (ctrl_q.rise),
    .cap_evt  (cap_evt)
  );

  tcap_regs #(
    .DATA_W (DATA_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .ovf_evt   (ovf_evt),
    .cmp_evt   (cmp_evt),
    .cap_evt   (cap_evt),
    .ctrl_q    (ctrl_q),
    .flags_q   (flags_q),
    .cmp_q     (cmp_q),
    .cnt_wr    (cnt_wr),
    .cmp_wr    (cmp_wr),
    .wr_val    (wr_val),
    .irq       (irq)
  );

  assign irq_ovf = irq[FLG_OVF];
  assign irq_cmp = irq[FLG_CMP];
  assign irq_cap = irq[FLG_CAP];

endmodule

// File: rtl/tcap_timer16_chk.sv
module tcap_timer16_chk #(
  parameter int CNT_W = 16,
  parameter int CS_W  = 3,
  parameter int FLG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CS_W-1:0]  cs,
  input logic             coc_eff,
  input logic             cap_mode,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] wr_val,
  input logic             cnt_tick,
  input logic             cnt_wr,
  input logic             cmp_wr,
  input logic             ovf_evt,
  input logic             cap_evt,
  input logic [FLG_W-1:0] flags_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && flags_q == '0 && cmp_q == '0));

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs == '0 && !cnt_wr) |=> $stable(cnt_q));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !cnt_wr && !coc_eff) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  coc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && coc_eff && !cnt_wr && cnt_q == cmp_q) |=> (cnt_q == '0));

  // R5
  write_prio_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(wr_val)));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flags_q[0]);

  // R10
  cap_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && cap_mode && !cmp_wr) |=> (cmp_q == $past(cnt_q) && flags_q[2]));

  // R10
  cap_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode && !cmp_wr) |=> $stable(cmp_q));

endmodule

bind tcap_timer16 tcap_timer16_chk #(
  .CNT_W (CNT_W),
  .CS_W  (tcap_pkg::CS_W),
  .FLG_W (tcap_pkg::FLG_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cs       (ctrl_q.cs),
  .coc_eff  (coc_eff),
  .cap_mode (ctrl_q.cap_mode),
  .cnt_q    (cnt_q),
  .cmp_q    (cmp_q),
  .wr_val   (wr_val),
  .cnt_tick (cnt_tick),
  .cnt_wr   (cnt_wr),
  .cmp_wr   (cmp_wr),
  .ovf_evt  (ovf_evt),
  .cap_evt  (cap_evt),
  .flags_q  (flags_q)
);

// File: tb/tcap_timer16_tb_top.sv
module tcap_timer16_tb_top;
  import tcap_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [6:0] tick_src;
  logic       cap_pin;
  logic       acmp_out;
  logic       irq_ovf;
  logic       irq_cmp;
  logic       irq_cap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tcap_timer16 dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_src  (tick_src),
    .cap_pin   (cap_pin),
    .acmp_out  (acmp_out),
    .irq_ovf   (irq_ovf),
    .irq_cmp   (irq_cmp),
    .irq_cap   (irq_cap)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] start;
    logic [15:0] cmp;
    logic [6:0]  mask;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic [1:0]  exp_flg;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 16'h0000, 16'h0005, 7'h01, 8'd10, 16'h000A, 2'b10},
    '{8'h00, 16'h1234, 16'h1234, 7'h7F, 8'd20, 16'h1234, 2'b00},
    '{8'h03, 16'hFFFE, 16'h0100, 7'h04, 8'd5,  16'h0003, 2'b01},
    '{8'h02, 16'h0005, 16'h0005, 7'h01, 8'd8,  16'h0005, 2'b00},
    '{8'h09, 16'h0007, 16'h0009, 7'h01, 8'd5,  16'h0002, 2'b10},
    '{8'h09, 16'hFFFE, 16'hFFFF, 7'h01, 8'd3,  16'h0001, 2'b11},
    '{8'h07, 16'h00FF, 16'h0000, 7'h40, 8'd2,  16'h0101, 2'b00},
    '{8'h0B, 16'h0020, 16'h0010, 7'h04, 8'd3,  16'h0023, 2'b00},
    '{8'h05, 16'h0040, 16'h0000, 7'h0F, 8'd4,  16'h0040, 2'b00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo + 3'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic glitch(input int w);
    cap_pin = 1'b1;
    idle(w);
    cap_pin = 1'b0;
    idle(12);
  endtask

  task automatic run_latency(input bit nc, output logic [15:0] v);
    wr(A_CTRL, nc ? 8'h71 : 8'h51);
    cap_pin = 1'b0;
    idle(10);
    wr(A_FLAG, 8'hFF);
    tick_src = 7'h01;
    wr16(A_CNT_LO, 16'h0000);
    idle(3);
    cap_pin = 1'b1;
    idle(12);
    tick_src = 7'h00;
    rd16(A_CMP_LO, v);
    cap_pin = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic [15:0] lat_off, lat_on;

    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    tick_src = '0; cap_pin = 1'b0; acmp_out = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    check("R1 rdata", {8'h00, bus_rdata}, 16'h0000);
    check("R1 irq", {13'd0, irq_ovf, irq_cmp, irq_cap}, 16'h0000);
    rd(A_CTRL, b);     check("R1 ctrl", {8'h00, b}, 16'h0000);
    rd(A_FLAG, b);     check("R1 flags", {8'h00, b}, 16'h0000);
    rd16(A_CNT_LO, w); check("R1 count", w, 16'h0000);
    rd16(A_CMP_LO, w); check("R1 compare", w, 16'h0000);

    // Vector table: R2 select, R3 wrap, R4 clear-on-compare, R6 flags
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CTRL, VECS[i].ctrl);
      wr16(A_CMP_LO, VECS[i].cmp);
      wr16(A_CNT_LO, VECS[i].start);
      wr(A_FLAG, 8'hFF);
      tick_src = VECS[i].mask;
      idle(VECS[i].n);
      tick_src = 7'h00;
      rd16(A_CNT_LO, w);
      check("R2/R3/R4 vector count", w, VECS[i].exp_cnt);
      rd(A_FLAG, b);
      check("R6 vector flags", {14'd0, b[1:0]}, {14'd0, VECS[i].exp_flg});
    end

    // R5: count write beats increment
    wr(A_CTRL, 8'h01);
    wr(A_CNT_HI, 8'h50);
    tick_src = 7'h01;
    wr(A_CNT_LO, 8'h00);
    tick_src = 7'h00;
    rd16(A_CNT_LO, w); check("R5 write over increment", w, 16'h5000);

    // R5: count write beats clear-on-compare
    wr(A_CTRL, 8'h09);
    wr16(A_CMP_LO, 16'h0003);
    wr16(A_CNT_LO, 16'h0003);
    wr(A_CNT_HI, 8'h00);
    tick_src = 7'h01;
    wr(A_CNT_LO, 8'h40);
    tick_src = 7'h00;
    rd16(A_CNT_LO, w); check("R5 write over clear", w, 16'h0040);

    // R7: set wins over clear, zero write no effect, one clears
    wr(A_CTRL, 8'h01);
    wr16(A_CMP_LO, 16'h8000);
    wr16(A_CNT_LO, 16'hFFFF);
    tick_src = 7'h01; idle(1); tick_src = 7'h00;
    wr16(A_CNT_LO, 16'hFFFF);
    tick_src = 7'h01;
    wr(A_FLAG, 8'h01);
    tick_src = 7'h00;
    rd(A_FLAG, b);     check("R7 set wins", {15'd0, b[0]}, 16'h0001);
    rd16(A_CNT_LO, w); check("R3 wrap during clear", w, 16'h0000);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, b);     check("R7 zero write keeps", {15'd0, b[0]}, 16'h0001);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, b);     check("R7 one clears", {15'd0, b[0]}, 16'h0000);

    // R12: temporary byte
    wr(A_CTRL, 8'h00);
    wr16(A_CNT_LO, 16'h12FF);
    rd(A_CNT_LO, b);   check("R12 low read", {8'h00, b}, 16'h00FF);
    wr(A_CTRL, 8'h01);
    tick_src = 7'h01; idle(1); tick_src = 7'h00;
    rd(A_CNT_HI, b);   check("R12 latched high", {8'h00, b}, 16'h0012);
    wr(A_CNT_HI, 8'h77);
    rd16(A_CNT_LO, w); check("R12 high write alone", w, 16'h1300);

    // R10/R9: rising capture with stopped counter
    wr(A_CTRL, 8'h50);
    wr16(A_CNT_LO, 16'h1ABC);
    wr16(A_CMP_LO, 16'h0000);
    wr(A_FLAG, 8'hFF);
    cap_pin = 1'b1; idle(10);
    rd(A_FLAG, b);     check("R10 capture flag", {13'd0, b[2:0]}, 16'h0004);
    rd16(A_CMP_LO, w); check("R10 capture value", w, 16'h1ABC);

    // R13: interrupt gating
    wr(A_IEN, 8'h00);
    check("R13 masked", {13'd0, irq_ovf, irq_cmp, irq_cap}, 16'h0000);
    wr(A_IEN, 8'h04);
    check("R13 enabled", {13'd0, irq_ovf, irq_cmp, irq_cap}, 16'h0001);
    wr(A_IEN, 8'h00);

    // R9: falling edge ignored when rising selected
    wr(A_FLAG, 8'hFF);
    wr16(A_CNT_LO, 16'h2222);
    cap_pin = 1'b0; idle(10);
    rd(A_FLAG, b);     check("R9 wrong edge flag", {15'd0, b[2]}, 16'h0000);
    rd16(A_CMP_LO, w); check("R9 wrong edge value", w, 16'h1ABC);

    // R9: falling selected
    wr(A_CTRL, 8'h10);
    cap_pin = 1'b1; idle(10);
    wr(A_FLAG, 8'hFF);
    cap_pin = 1'b0; idle(10);
    rd(A_FLAG, b);     check("R9 falling flag", {15'd0, b[2]}, 16'h0001);
    rd16(A_CMP_LO, w); check("R9 falling value", w, 16'h2222);

    // R8: comparator source, pin ignored
    wr(A_CTRL, 8'hD0);
    wr16(A_CNT_LO, 16'h3333);
    wr(A_FLAG, 8'hFF);
    cap_pin = 1'b1; idle(10);
    rd(A_FLAG, b);     check("R8 pin ignored", {15'd0, b[2]}, 16'h0000);
    acmp_out = 1'b1; idle(10);
    rd(A_FLAG, b);     check("R8 comparator flag", {15'd0, b[2]}, 16'h0001);
    rd16(A_CMP_LO, w); check("R8 comparator value", w, 16'h3333);
    acmp_out = 1'b0; cap_pin = 1'b0; idle(10);

    // R10: capture mode off ignores edges
    wr(A_CTRL, 8'h40);
    wr16(A_CMP_LO, 16'h0AAA);
    wr(A_FLAG, 8'hFF);
    cap_pin = 1'b1; idle(10);
    rd(A_FLAG, b);     check("R10 off flag", {15'd0, b[2]}, 16'h0000);
    rd16(A_CMP_LO, w); check("R10 off register", w, 16'h0AAA);
    cap_pin = 1'b0; idle(10);

    // R11: noise canceler
    wr(A_CTRL, 8'h50);
    wr(A_FLAG, 8'hFF);
    glitch(2);
    rd(A_FLAG, b);     check("R11 short pulse passes when off", {15'd0, b[2]}, 16'h0001);
    wr(A_CTRL, 8'h70);
    idle(10);
    wr(A_FLAG, 8'hFF);
    glitch(2);
    rd(A_FLAG, b);     check("R11 2-clock pulse rejected", {15'd0, b[2]}, 16'h0000);
    glitch(4);
    rd(A_FLAG, b);     check("R11 4-clock pulse rejected", {15'd0, b[2]}, 16'h0000);
    glitch(6);
    rd(A_FLAG, b);     check("R11 6-clock pulse accepted", {15'd0, b[2]}, 16'h0001);

    run_latency(1'b0, lat_off);
    run_latency(1'b1, lat_on);
    check("R11 added latency", lat_on - lat_off, 16'd4);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule